// File: doc/BRIEF.md
# Two-Register Byte Processor Core

This block is a small single-cycle processor built around two 8-bit general registers, called A and B. Around them sit an 8-bit program counter, a 256-byte data RAM inside the block, an output register, and a one-byte input holding register with a pending flag.

The core reads one 16-bit instruction word from an external program memory at the address it drives. It executes that instruction on the next rising clock edge. The instruction set has sixteen operations:

- Loads from an immediate value or from RAM.
- Stores to RAM.
- A register swap.
- Add and subtract.
- Output.
- A conditional input.
- Jumps, some of which use register B as the address.

An external producer offers bytes with a one-cycle valid strobe. Software polls for them with the conditional input instruction. That instruction branches only when a byte is waiting and otherwise falls through. Results leave the core through the output byte. A one-cycle update pulse marks each new value.

Top module: `duo_core`

## Requirements
- R1: An instruction word carries its opcode in bits 7:0 and its immediate byte in bits 15:8. The opcode values are: 0 idle, 1 load A from RAM[imm], 2 load B from RAM[imm], 3 A=imm, 4 B=imm, 5 load A from RAM[B], 6 store A to RAM[B], 7 store A to RAM[imm], 8 swap, 9 add, 10 subtract, 11 output, 12 conditional input, 13 jump to imm, 14 jump to B, 15 jump to imm if A is zero. Opcodes above 15 act as opcode 0.
- R2: While reset is high at a rising edge, the program counter, A, B, the output byte, the update pulse and the pending flag are all cleared to 0. The RAM keeps its contents.
- R3: Opcodes 3 and 4 write the immediate byte into A or B. Opcodes 1 and 2 write RAM[imm] into A or B.
- R4: Opcode 7 writes A to RAM[imm]. Opcode 6 writes A to RAM[B]. Opcode 5 reads RAM[B] into A.
- R5: Opcode 8 exchanges A and B in one instruction.
- R6: Opcode 9 sets A to (A+B) mod 256. Opcode 10 sets A to (A-B) mod 256. No carry or borrow is kept.
- R7: Opcode 11 loads (A+B) mod 256 into the output byte. out_update is high for exactly the one cycle that follows each output instruction.
- R8: in_valid latches in_byte and sets the pending flag. When the flag is set, opcode 12 loads the latched byte into A, jumps to imm and clears the flag. When the flag is clear, opcode 12 only advances the program counter.
- R9: Opcode 13 jumps to imm. Opcode 14 jumps to B. Opcode 15 jumps to imm when A is 0 and otherwise advances.
- R10: Every instruction that does not jump advances the program counter by 1, wrapping from 255 to 0.
- R11: If in_valid arrives in the same cycle as a taken opcode 12, A receives the byte latched earlier. The new byte is stored, and the pending flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous reset, active high |
| imem_addr | output | 8 | Program counter, the address of the instruction to run |
| imem_word | input | 16 | Instruction word read combinationally at imem_addr |
| in_byte | input | 8 | Byte offered by the external producer |
| in_valid | input | 1 | One-cycle strobe that latches in_byte |
| out_byte | output | 8 | Output register |
| out_update | output | 1 | High for the cycle after each output instruction |

## Verification
Every result of an instruction appears one rising edge after the edge at which that instruction's word is presented. This applies to a new imem_addr, a changed out_byte and the out_update pulse. A strobed byte can influence, at the earliest, the conditional input that executes on the following edge. The bench advances its behavioural model on the same rising edge as the core and compares imem_addr, out_byte and out_update at the next falling edge, so each comparison sees exactly one executed instruction. Register and RAM effects are made visible through later output instructions and conditional jumps in the test programs.

// File: rtl/duo_core_pkg.sv
package duo_core_pkg;
  parameter int unsigned WORD_W = 8;
  parameter int unsigned OPC_W  = 8;
  parameter int unsigned IMM_W  = WORD_W;
  parameter int unsigned INSN_W = OPC_W + IMM_W;

  typedef logic [WORD_W-1:0] word_t;

  typedef enum logic [3:0] {
    OP_IDLE, OP_LDM_A, OP_LDM_B, OP_SET_A, OP_SET_B, OP_LDIND_A, OP_STIND,
    OP_STIMM, OP_XCHG, OP_PLUS, OP_MINUS, OP_EMIT, OP_POLL, OP_GOTO,
    OP_GOTO_B, OP_GOTO_Z
  } op_e;

  typedef enum logic [2:0] {A_KEEP, A_IMM, A_RAM, A_FROM_B, A_ALU, A_INPUT} a_sel_e;
  typedef enum logic [1:0] {B_KEEP, B_IMM, B_RAM, B_FROM_A} b_sel_e;
  typedef enum logic [2:0] {PC_SEQ, PC_IMM, PC_REGB, PC_IMM_ZERO, PC_IMM_INPUT} pc_sel_e;

  typedef struct packed {
    a_sel_e  a_sel;
    b_sel_e  b_sel;
    pc_sel_e pc_sel;
    logic    addr_from_b;
    logic    ram_we;
    logic    is_sub;
    logic    out_ld;
    logic    in_try;
  } ctrl_t;

  function automatic word_t wrap_add(input word_t x, input word_t y);
    return x + y;
  endfunction

  function automatic word_t wrap_sub(input word_t x, input word_t y);
    return x - y;
  endfunction
endpackage

// File: rtl/duo_core_decode.sv
module duo_core_decode
  import duo_core_pkg::*;
(
  input  logic [OPC_W-1:0] opc,
  output ctrl_t            ctrl
);
  op_e op;

  always_comb begin
    op = op_e'(opc[3:0]);
    ctrl = '{a_sel: A_KEEP, b_sel: B_KEEP, pc_sel: PC_SEQ, addr_from_b: 1'b0,
             ram_we: 1'b0, is_sub: 1'b0, out_ld: 1'b0, in_try: 1'b0};
    // R1: any opcode with upper bits set behaves as idle
    if (opc[OPC_W-1:4] == '0) begin
      unique case (op)
        OP_IDLE:    ;
        OP_LDM_A:   ctrl.a_sel = A_RAM;
        OP_LDM_B:   ctrl.b_sel = B_RAM;
        OP_SET_A:   ctrl.a_sel = A_IMM;
        OP_SET_B:   ctrl.b_sel = B_IMM;
        OP_LDIND_A: begin ctrl.a_sel = A_RAM; ctrl.addr_from_b = 1'b1; end
        OP_STIND:   begin ctrl.ram_we = 1'b1; ctrl.addr_from_b = 1'b1; end
        OP_STIMM:   ctrl.ram_we = 1'b1;
        OP_XCHG:    begin ctrl.a_sel = A_FROM_B; ctrl.b_sel = B_FROM_A; end
        OP_PLUS:    ctrl.a_sel = A_ALU;
        OP_MINUS:   begin ctrl.a_sel = A_ALU; ctrl.is_sub = 1'b1; end
        OP_EMIT:    ctrl.out_ld = 1'b1;
        OP_POLL:    begin ctrl.a_sel = A_INPUT; ctrl.pc_sel = PC_IMM_INPUT; ctrl.in_try = 1'b1; end
        OP_GOTO:    ctrl.pc_sel = PC_IMM;
        OP_GOTO_B:  ctrl.pc_sel = PC_REGB;
        OP_GOTO_Z:  ctrl.pc_sel = PC_IMM_ZERO;
        default:    ;
      endcase
    end
  end
endmodule

// File: rtl/duo_core_dataram.sv
module duo_core_dataram #(
  parameter int unsigned AW = 8,
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int unsigned DEPTH = 1 << AW;

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];
endmodule

// File: rtl/duo_core_inport.sv
module duo_core_inport #(
  parameter int unsigned DW = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          strobe,
  input  logic [DW-1:0] byte_in,
  input  logic          consume,
  output logic [DW-1:0] data,
  output logic          pending
);
  always_ff @(posedge clk) begin
    if (rst) begin
      data    <= '0;
      pending <= 1'b0;
    end else if (strobe) begin
      data    <= byte_in;
      pending <= 1'b1;
    end else if (consume) begin
      pending <= 1'b0;
    end
  end

  // R8
  pend_set_chk: assert property (@(posedge clk) disable iff (rst)
    strobe |=> (pending && data == $past(byte_in)));

  // R8
  pend_clr_chk: assert property (@(posedge clk) disable iff (rst)
    (consume && !strobe) |=> !pending);

  // R11
  pend_keep_chk: assert property (@(posedge clk) disable iff (rst)
    (consume && strobe) |=> pending);
endmodule

// File: rtl/duo_core.sv
module duo_core
  import duo_core_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  output logic [WORD_W-1:0] imem_addr,
  input  logic [INSN_W-1:0] imem_word,
  input  logic [WORD_W-1:0] in_byte,
  input  logic              in_valid,
  output logic [WORD_W-1:0] out_byte,
  output logic              out_update
);
  ctrl_t ctrl;
  word_t pc_q, a_q, b_q, out_q, imm, ram_addr, ram_rdata;
  word_t sum, diff, alu_res, in_data, pc_next, a_next, b_next;
  logic  out_upd_q, a_zero, in_pending, in_taken, jump_taken;

  assign imm = imem_word[INSN_W-1:OPC_W];

  duo_core_decode u_dec (.opc(imem_word[OPC_W-1:0]), .ctrl(ctrl));

  assign ram_addr = ctrl.addr_from_b ? b_q : imm;

  duo_core_dataram #(.AW(WORD_W), .DW(WORD_W)) u_ram (
    .clk(clk), .we(ctrl.ram_we), .addr(ram_addr), .wdata(a_q), .rdata(ram_rdata)
  );

  assign in_taken = ctrl.in_try && in_pending;

  duo_core_inport #(.DW(WORD_W)) u_inp (
    .clk(clk), .rst(rst), .strobe(in_valid), .byte_in(in_byte),
    .consume(in_taken), .data(in_data), .pending(in_pending)
  );

  assign sum     = wrap_add(a_q, b_q);
  assign diff    = wrap_sub(a_q, b_q);
  assign alu_res = ctrl.is_sub ? diff : sum;
  assign a_zero  = (a_q == '0);

  always_comb begin
    unique case (ctrl.pc_sel)
      PC_SEQ:       jump_taken = 1'b0;
      PC_IMM:       jump_taken = 1'b1;
      PC_REGB:      jump_taken = 1'b1;
      PC_IMM_ZERO:  jump_taken = a_zero;
      PC_IMM_INPUT: jump_taken = in_pending;
      default:      jump_taken = 1'b0;
    endcase
    if (!jump_taken)                 pc_next = pc_q + 1'b1;
    else if (ctrl.pc_sel == PC_REGB) pc_next = b_q;
    else                             pc_next = imm;
  end

  always_comb begin
    unique case (ctrl.a_sel)
      A_KEEP:   a_next = a_q;
      A_IMM:    a_next = imm;
      A_RAM:    a_next = ram_rdata;
      A_FROM_B: a_next = b_q;
      A_ALU:    a_next = alu_res;
      A_INPUT:  a_next = in_pending ? in_data : a_q;
      default:  a_next = a_q;
    endcase
    unique case (ctrl.b_sel)
      B_KEEP:   b_next = b_q;
      B_IMM:    b_next = imm;
      B_RAM:    b_next = ram_rdata;
      B_FROM_A: b_next = a_q;
      default:  b_next = b_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q      <= '0;
      a_q       <= '0;
      b_q       <= '0;
      out_q     <= '0;
      out_upd_q <= 1'b0;
    end else begin
      pc_q      <= pc_next;
      a_q       <= a_next;
      b_q       <= b_next;
      out_upd_q <= ctrl.out_ld;
      if (ctrl.out_ld) out_q <= alu_res;
    end
  end

  assign imem_addr  = pc_q;
  assign out_byte   = out_q;
  assign out_update = out_upd_q;

  // R10
  pc_step_chk: assert property (@(posedge clk) disable iff (rst)
    !jump_taken |=> (pc_q == word_t'($past(pc_q) + 1'b1)));

  // R9
  jz_target_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl.pc_sel == PC_IMM_ZERO && a_zero) |=> (pc_q == $past(imm)));

  // R7
  out_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    ctrl.out_ld |=> (out_update && out_byte == wrap_add($past(a_q), $past(b_q))));

  // R7
  out_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !ctrl.out_ld |=> (!out_update && $stable(out_byte)));

  // R5
  swap_chk: assert property (@(posedge clk) disable iff (rst)
    (ctrl.a_sel == A_FROM_B && ctrl.b_sel == B_FROM_A) |=>
      (a_q == $past(b_q) && b_q == $past(a_q)));

  // R8
  in_jump_chk: assert property (@(posedge clk) disable iff (rst)
    in_taken |=> (pc_q == $past(imm) && a_q == $past(in_data)));
endmodule

// File: tb/duo_core_tb_top.sv
module duo_core_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic [7:0]  imem_addr;
  logic [15:0] imem_word;
  logic [7:0]  in_byte;
  logic        in_valid;
  logic [7:0]  out_byte;
  logic        out_update;

  always #10ns clk = ~clk;

  logic [15:0] prog [256];
  assign imem_word = prog[imem_addr];

  duo_core dut_i (
    .clk(clk), .rst(rst), .imem_addr(imem_addr), .imem_word(imem_word),
    .in_byte(in_byte), .in_valid(in_valid), .out_byte(out_byte), .out_update(out_update)
  );

  int checks = 0;
  int failures = 0;
  bit started = 0;
  bit done = 0;

  // behavioural reference state
  byte unsigned m_pc, m_a, m_b, m_out, m_in, tmp;
  bit           m_upd, m_pend;
  byte unsigned m_ram [256];
  string        m_tag = "R2";
  bit           m_jump_op;

  function automatic string req_of(input int op, input bit race);
    if (race) return "R11";
    case (op)
      1, 2, 3, 4:   return "R3";
      5, 6, 7:      return "R4";
      8:            return "R5";
      9, 10:        return "R6";
      11:           return "R7";
      12:           return "R8";
      13, 14, 15:   return "R9";
      default:      return "R1";
    endcase
  endfunction

  always @(posedge clk) begin
    int op;
    byte unsigned imm, np;
    bit consume;
    op = int'(prog[m_pc][7:0]);
    imm = prog[m_pc][15:8];
    if (rst) begin
      m_pc = 0; m_a = 0; m_b = 0; m_out = 0; m_upd = 0; m_pend = 0; m_in = 0;
      m_tag = "R2"; m_jump_op = 1;
    end else begin
      np = m_pc + 8'd1;
      consume = 0;
      m_upd = 0;
      case (op)
        1:  m_a = m_ram[imm];
        2:  m_b = m_ram[imm];
        3:  m_a = imm;
        4:  m_b = imm;
        5:  m_a = m_ram[m_b];
        6:  m_ram[m_b] = m_a;
        7:  m_ram[imm] = m_a;
        8:  begin tmp = m_a; m_a = m_b; m_b = tmp; end
        9:  m_a = m_a + m_b;
        10: m_a = m_a - m_b;
        11: begin m_out = m_a + m_b; m_upd = 1; end
        12: if (m_pend) begin m_a = m_in; np = imm; consume = 1; end
        13: np = imm;
        14: np = m_b;
        15: if (m_a == 0) np = imm;
        default: ;
      endcase
      m_tag = req_of(op, consume && in_valid);
      m_jump_op = (op >= 12 && op <= 15);
      m_pc = np;
      if (in_valid) begin m_in = in_byte; m_pend = 1; end
      else if (consume) m_pend = 0;
    end
    started = 1;
  end

  always @(negedge clk) begin
    if (started && !done) begin
      checks++;
      if (imem_addr !== m_pc) begin
        failures++;
        $display("FAIL %s%s pc: actual=%0d expected=%0d", m_tag,
                 m_jump_op ? "" : "/R10", imem_addr, m_pc);
      end
      checks++;
      if (out_byte !== m_out || out_update !== m_upd) begin
        failures++;
        $display("FAIL R7/%s out: actual=%0d/%0b expected=%0d/%0b", m_tag,
                 out_byte, out_update, m_out, m_upd);
      end
    end
  end

  task automatic put(input int addr, input int op, input int imm);
    prog[addr] = {8'(imm), 8'(op)};
  endtask

  task automatic clear_prog();
    for (int i = 0; i < 256; i++) prog[i] = 16'h0000;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    in_valid = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    checks++; // R2 reset state
    if (imem_addr !== 8'd0 || out_byte !== 8'd0 || out_update !== 1'b0) begin
      failures++;
      $display("FAIL R2 reset: actual=%0d/%0d/%0b expected=0/0/0", imem_addr, out_byte, out_update);
    end
    rst = 1'b0;
  endtask

  // mode 0: no strobes, 1: sparse strobes, 2: strobe every cycle
  task automatic run(input int n, input int mode);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      in_byte  = 8'(i * 13 + 1);
      in_valid = (mode == 2) || (mode == 1 && (i % 7) == 3);
    end
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    rst = 1'b1;
    in_valid = 1'b0;
    in_byte = 8'd0;
    clear_prog();
    // program 1: loads, stores, arithmetic, output, jumps, wrap
    put(0, 3, 5);    put(1, 4, 3);    put(2, 11, 0);   put(3, 10, 0);
    put(4, 4, 0);    put(5, 11, 0);   put(6, 3, 250);  put(7, 4, 10);
    put(8, 9, 0);    put(9, 7, 32);   put(10, 3, 7);   put(11, 7, 33);
    put(12, 2, 32);  put(13, 3, 0);   put(14, 11, 0);  put(15, 1, 33);
    put(16, 8, 0);   put(17, 10, 0);  put(18, 4, 0);   put(19, 11, 0);
    put(20, 4, 64);  put(21, 3, 9);   put(22, 6, 0);   put(23, 3, 0);
    put(24, 5, 0);   put(25, 4, 0);   put(26, 11, 0);  put(27, 8'h7F, 8'h33);
    put(28, 8'h10, 0); put(29, 15, 80); put(30, 3, 0); put(31, 15, 80);
    put(80, 4, 96);  put(81, 14, 0);  put(96, 13, 253);
    put(253, 3, 1);  put(254, 11, 0); put(255, 8'hFF, 8'hFF);
    do_reset();
    run(90, 1);
    // program 2: input polling with conditional input
    clear_prog();
    put(0, 12, 16);  put(1, 13, 0);
    put(16, 4, 0);   put(17, 11, 0);  put(18, 13, 0);
    do_reset();
    run(40, 0);
    run(80, 1);
    run(40, 2);
    run(30, 0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule